// File: doc/BRIEF.md
# Ring Signal Duty-Cycle Qualifier

This block decides whether an incoming telephone ring is real by integrating the duty cycle of a one-bit comparator signal. The signal is high while the attenuated ring is above the analog threshold. A saturating counter steps up on a fast tick while the synchronized input is high. It steps down on a tick at half that rate while the input is low. Short bursts and low duty cycles therefore never build up enough count, while a sustained ring does.

A qualified flag sets at a high count and clears only at a lower one. This hysteresis keeps the detector steady across the gaps inside each ring cycle. The flag drives an active-low ring-detect output. That output can wake the rest of the chip or feed back into the power-mode logic. Both ticks come from one internal prescaler whose divide ratio is a parameter, so the block runs from any system clock. An enable input from the power-mode logic holds the whole integrator cleared while the block is not in use.

Top module: `ring_qualifier`

## Requirements
- R1: While the synchronized input is high and the block is enabled, the count rises by one on every fast tick. The fast tick occurs once every TICK_DIV clocks, and the first one comes on the TICK_DIV-th enabled clock edge.
- R2: While the synchronized input is low, the count falls by one on every slow tick. A slow tick is every second fast tick, starting with the second one after enable, so falling runs at half the rising rate.
- R3: The qualified state is entered on the clock edge where the count reaches QUAL_LEVEL (default 48). With the input steadily high, ringDetN falls on enabled edge 48*TICK_DIV.
- R4: Once qualified, the state holds while the count stays above DROP_LEVEL (default 32). It ends on the edge where the count falls to DROP_LEVEL.
- R5: The count saturates at 2**CNT_W-1 (63) and never wraps to zero.
- R6: The count saturates at 0 and never wraps to the maximum.
- R7: While enable is low, the count is held at 0, the qualified state is cleared and ringDetN is high. The count restarts from 0 when enable returns.
- R8: A square input with 50 % duty cycle qualifies. A square input with 25 % duty cycle never qualifies.
- R9: ringAboveThr passes through a two-flop synchronizer. A level applied on the same edge as enable is first counted two clock edges later.
- R10: ringDetN is low exactly while the ring is qualified. It is high out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable from power-mode logic; low clears the integrator |
| ringAboveThr | input | 1 | Asynchronous comparator output, high while ring is above threshold |
| ringDetN | output | 1 | Active-low ring qualified indication |

## Verification
With the input settled before enable, ringDetN must fall exactly on edge 48*TICK_DIV, and the bench samples it on the falling clock edge just before and just after that edge. When the input and enable rise together, the two synchronizer stages delay the first count by one tick, so the fall moves to edge 49*TICK_DIV, which is checked the same way. For events that depend on where the tick phase lies when the input changes (dequalification from saturation or from the qualify point, and qualification after a long low), the bench derives a window from the tick spacing plus two synchronizer cycles. It checks that the output has not yet changed before the window and has changed after it. Enable removal must raise ringDetN one edge later, and that is sampled on the next falling edge.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef struct packed {
    logic clear;  // enable deasserted: hold integrator cleared
    logic incr;   // fast tick with input high
    logic decr;   // slow tick with input low
  } rqStrobe_t;
endpackage

// File: rtl/rq_ctrl.sv
module rq_ctrl
  import rq_pkg::*;
#(
  parameter int TICK_DIV    = 312500,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      ringAboveThr,
  output rqStrobe_t strobe
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [PW-1:0]          preCnt;
  logic                   halfPhase;
  logic                   fastTick;
  logic                   slowTick;
  logic                   levelHigh;

  // synchronizer chain, one flop per stage
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          syncQ[g] <= 1'b0;
        else if (g == 0)    syncQ[g] <= ringAboveThr;
        else                syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign levelHigh = syncQ[SYNC_STAGES-1];

  // single prescaler chain: fast tick, slow tick every other fast tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= '0;
      halfPhase <= 1'b0;
    end else if (!enable) begin
      preCnt    <= '0;
      halfPhase <= 1'b0;
    end else begin
      preCnt <= fastTick ? '0 : preCnt + 1'b1;
      if (fastTick) halfPhase <= ~halfPhase;
    end
  end

  assign fastTick = enable && (preCnt == LAST);
  assign slowTick = fastTick && halfPhase;

  always_comb begin
    strobe.clear = !enable;
    strobe.incr  = fastTick && levelHigh;
    strobe.decr  = slowTick && !levelHigh;
  end

  // R1 R2: never step both ways at once
  a_r2_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clear, strobe.incr, strobe.decr}));

  // R9: a count-up needs the input high two edges earlier
  a_r9_sync_delay: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incr |-> $past(ringAboveThr, 2));

  // R2: two slow-tick decrements are never on adjacent fast ticks
  a_r2_half_rate: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decr |=> !strobe.decr);
endmodule

// File: rtl/rq_count.sv
module rq_count
  import rq_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int QUAL_LEVEL = 48,
  parameter int DROP_LEVEL = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  rqStrobe_t strobe,
  output logic      qualified
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] QUAL_C  = CNT_W'(QUAL_LEVEL);
  localparam logic [CNT_W-1:0] DROP_C  = CNT_W'(DROP_LEVEL);

  logic [CNT_W-1:0] cntQ, cntNext;
  logic             qualNext;

  always_comb begin
    cntNext = cntQ;
    if (strobe.clear)                          cntNext = '0;
    else if (strobe.incr && cntQ != CNT_MAX)   cntNext = cntQ + 1'b1;
    else if (strobe.decr && cntQ != '0)        cntNext = cntQ - 1'b1;

    qualNext = qualified;
    if (strobe.clear)            qualNext = 1'b0;
    else if (cntNext >= QUAL_C)  qualNext = 1'b1;
    else if (cntNext <= DROP_C)  qualNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ      <= '0;
      qualified <= 1'b0;
    end else begin
      cntQ      <= cntNext;
      qualified <= qualNext;
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == CNT_MAX && !strobe.clear && !strobe.decr) |=> cntQ == CNT_MAX);

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == '0 && !strobe.incr) |=> cntQ == '0);

  a_r3_qualify_point: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qualified) |-> cntQ == QUAL_C);

  a_r4_drop_point: assert property (@(posedge clk) disable iff (!rstN)
    $fell(qualified) |-> (cntQ == DROP_C || cntQ == '0));

  a_r7_clear_hold: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (cntQ == '0 && !qualified));
endmodule

// File: rtl/ring_qualifier.sv
module ring_qualifier
  import rq_pkg::*;
#(
  parameter int TICK_DIV   = 312500,
  parameter int CNT_W      = 6,
  parameter int QUAL_LEVEL = 48,
  parameter int DROP_LEVEL = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic ringAboveThr,
  output logic ringDetN
);
  rqStrobe_t strobe;
  logic      qualified;

  rq_ctrl #(.TICK_DIV(TICK_DIV), .SYNC_STAGES(2)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .ringAboveThr(ringAboveThr), .strobe(strobe)
  );

  rq_count #(.CNT_W(CNT_W), .QUAL_LEVEL(QUAL_LEVEL), .DROP_LEVEL(DROP_LEVEL)) i_count (
    .clk(clk), .rstN(rstN), .strobe(strobe), .qualified(qualified)
  );

  assign ringDetN = ~qualified;

  // R10 R7: output high whenever disabled for a cycle
  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ringDetN);
endmodule

// File: tb/test_ring_qualifier.sv
module test_ring_qualifier;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic ringAboveThr = 1'b0;
  logic ringDetN;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  ring_qualifier #(.TICK_DIV(DIV)) i_ring_qualifier (
    .clk(clk), .rstN(rstN), .enable(enable),
    .ringAboveThr(ringAboveThr), .ringDetN(ringDetN)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: ringDetN actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic disableAll();
    @(negedge clk);
    enable = 1'b0;
    ringAboveThr = 1'b0;
    edges(4);
  endtask

  task automatic testReset();
    edges(1);
    check(ringDetN, 1'b1, "R10 reset state high");
  endtask

  // input settled before enable: fall on edge 48*DIV
  task automatic testQualifyExact();
    disableAll();
    ringAboveThr = 1'b1;
    edges(4);
    check(ringDetN, 1'b1, "R7 high while disabled with input high");
    enable = 1'b1;
    edges(48*DIV - 1);
    check(ringDetN, 1'b1, "R1 R3 not yet qualified on edge 47 ticks");
    edges(1);
    check(ringDetN, 1'b0, "R1 R3 qualified on edge 48 ticks");
  endtask

  task automatic testEnableClear();
    // continues from qualified state
    enable = 1'b0;
    edges(1);
    check(ringDetN, 1'b1, "R7 disable raises output next edge");
    enable = 1'b1;
    edges(48*DIV - 1);
    check(ringDetN, 1'b1, "R7 count restarted from zero");
    edges(1);
    check(ringDetN, 1'b0, "R7 requalified after full 48 ticks");
  endtask

  // input and enable together: synchronizer costs one tick at DIV=2
  task automatic testSync();
    disableAll();
    enable = 1'b1;
    ringAboveThr = 1'b1;
    edges(49*DIV - 1);
    check(ringDetN, 1'b1, "R9 first count delayed by synchronizer");
    edges(1);
    check(ringDetN, 1'b0, "R9 qualified on edge 49 ticks");
  endtask

  // saturate high, then dequalify: 31 slow ticks from 63
  task automatic testSaturateHigh();
    disableAll();
    enable = 1'b1;
    ringAboveThr = 1'b1;
    edges(200*DIV);
    ringAboveThr = 1'b0;
    edges(118);
    check(ringDetN, 1'b0, "R5 R2 still qualified: count saturated at 63");
    edges(12);
    check(ringDetN, 1'b1, "R2 R4 dequalified after 31 slow ticks");
  endtask

  // hysteresis: drop from qualify point needs 16 slow ticks
  task automatic testHysteresis();
    int waited = 0;
    disableAll();
    enable = 1'b1;
    ringAboveThr = 1'b1;
    while (ringDetN === 1'b1 && waited < 400) begin
      edges(1);
      waited++;
    end
    ringAboveThr = 1'b0;
    check(ringDetN, 1'b0, "R3 reached qualified state");
    edges(50);
    check(ringDetN, 1'b0, "R4 held between 48 and 32");
    edges(30);
    check(ringDetN, 1'b1, "R4 released at 32");
  endtask

  // long low then high: qualify time unchanged if zero saturates
  task automatic testSaturateLow();
    disableAll();
    enable = 1'b1;
    edges(200);
    check(ringDetN, 1'b1, "R6 idle low input stays unqualified");
    ringAboveThr = 1'b1;
    edges(90);
    check(ringDetN, 1'b1, "R6 no wrap to max at zero");
    edges(14);
    check(ringDetN, 1'b0, "R6 qualified after 48 ticks from zero");
  endtask

  task automatic runDuty(input int highCycles, input int periods, output logic sawLow);
    sawLow = 1'b0;
    for (int p = 0; p < periods; p++) begin
      for (int c = 0; c < 64; c++) begin
        ringAboveThr = (c < highCycles);
        edges(1);
        if (ringDetN === 1'b0) sawLow = 1'b1;
      end
    end
  endtask

  task automatic testDuty();
    logic sawLow;
    disableAll();
    enable = 1'b1;
    runDuty(16, 50, sawLow);
    check(sawLow, 1'b0, "R8 25% duty never qualifies");
    disableAll();
    enable = 1'b1;
    runDuty(32, 25, sawLow);
    check(sawLow, 1'b1, "R8 50% duty qualifies");
  endtask

  initial begin
    edges(3);
    rstN = 1'b1;
    testReset();
    testQualifyExact();
    testEnableClear();
    testSync();
    testSaturateHigh();
    testHysteresis();
    testSaturateLow();
    testDuty();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule